// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a register-driven management-bus master. It runs one Clause 22 read or write transaction at a time against an external PHY. Software first loads a 16-bit data register. It then writes a command word that packs the PHY address, the PHY register number, a direction flag, a clock-ratio select and a start/busy flag.

While busy is set, the engine makes the management clock from the core clock. It shifts out a complete frame and, for a read, releases the data line and gathers the 16 returned bits. When the frame ends it clears busy and MDC goes low again. On a read it also places the collected value in the data register, where software picks it up.

The register port is a single write strobe with a select line. Both registers are visible at all times on two read buses.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, busy is 0, MDC is 0, the output enable is 0, and both read buses read 0.
- R2: A command write whose bit 0 is 1, made while idle, starts a transaction. Busy (command bit 0) reads 1 from the next cycle. It stays 1 for exactly 128 MDC half periods, and then reads 0.
- R3: A write frame (command bit 1 = 1) carries the following bits MSB first: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, and then the 16 data-register bits. Each bit is stable at the MDC rising edge, and the enable is on for all 64 bits.
- R4: A read frame (command bit 1 = 0) carries opcode 10 and drives its first 46 bits. The enable is off from the turnaround (bit 46) to the end of the frame. MDIO is sampled on the rising edges of bits 48 to 63, MSB first, and that value is in the data register when busy clears.
- R5: Command bits 21:20 choose the MDC period as 16, 32, 64 or 128 core clocks for values 0, 1, 2 and 3.
- R6: A command write made while busy changes neither the command fields nor the running frame.
- R7: A data-register write made while busy is ignored.
- R8: MDC and the output enable are 0 whenever busy is 0.
- R9: The command read bus returns busy at bit 0, the write flag at bit 1, the register address at 8:4, the PHY address at 16:12 and the divider select at 21:20. All other bits read 0. A command write made while idle with bit 0 = 0 stores the fields and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the command register, 1 selects the data register |
| regWrData | input | 32 | Write data; the data register takes bits 15:0 |
| cmdRdData | output | 32 | Command register read value, including busy |
| dataRdData | output | 16 | Data register read value |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data driven toward the PHY |
| mdioOe | output | 1 | Output enable for mdioOut |
| mdioIn | input | 1 | Management data returned from the pad |

## Verification
The hardest cases to reach from the ports are register writes that land in the middle of a running frame, and read data that must arrive in step with MDC. The bench handles the first by issuing both a command write and a data write about a hundred cycles into every transaction. It then checks the whole captured frame, the read-back fields and the data register against the values in place before the transaction. For the second, a PHY model counts MDC rising edges and changes mdioIn only after falling edges in the data phase, so a wrong sampling edge or a wrong bit order shows up in the latched result.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_W      = 32;
  localparam int FRAME_BITS = PRE_W + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int REL_BIT    = PRE_W + 2 + 2 + 2 * ADDR_W;
  localparam int DATA_START = FRAME_BITS - DATA_W;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic done;
  } mdio_strb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int BASE_HALF = 8,
  parameter int DIV_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             cmdWr,
  input  logic [DIV_W-1:0] cmdDiv,
  output mdio_strb_t       strb,
  output logic             busy,
  output logic             mdc,
  output logic             mdioOe
);
  localparam int MAX_HALF = BASE_HALF << ((1 << DIV_W) - 1);
  localparam int CW       = $clog2(MAX_HALF) + 1;
  localparam int BW       = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  logic [CW-1:0] halfCnt;
  logic [CW-1:0] halfLim;
  logic [BW-1:0] bitIdx;
  logic          edgeNow;

  assign halfLim = CW'(BASE_HALF) << cmdDiv;
  assign edgeNow = busy && (halfCnt == halfLim - CW'(1));

  always_comb begin
    strb.load   = !busy && startReq;
    strb.shift  = edgeNow && mdc && (bitIdx != LAST_BIT);
    strb.sample = edgeNow && !mdc && !cmdWr && (bitIdx >= BW'(DATA_START));
    strb.done   = edgeNow && mdc && (bitIdx == LAST_BIT);
  end

  assign mdioOe = busy && (cmdWr || (bitIdx < BW'(REL_BIT)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      mdc     <= 1'b0;
      halfCnt <= '0;
      bitIdx  <= '0;
    end else if (!busy) begin
      mdc <= 1'b0;
      if (startReq) begin
        busy    <= 1'b1;
        halfCnt <= '0;
        bitIdx  <= '0;
      end
    end else if (edgeNow) begin
      halfCnt <= '0;
      mdc     <= ~mdc;
      if (mdc) begin
        if (bitIdx == LAST_BIT) busy <= 1'b0;
        else bitIdx <= bitIdx + BW'(1);
      end
    end else begin
      halfCnt <= halfCnt + CW'(1);
    end
  end
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [31:0]      regWrData,
  input  mdio_strb_t       strb,
  input  logic             busy,
  input  logic             mdioIn,
  output logic             startReq,
  output logic             cmdWr,
  output logic [DIV_W-1:0] cmdDiv,
  output logic [31:0]      cmdRdData,
  output logic [DATA_W-1:0] dataRdData,
  output logic             mdioOut
);
  logic [ADDR_W-1:0]     cmdReg;
  logic [ADDR_W-1:0]     cmdPhy;
  logic [DATA_W-1:0]     dataReg;
  logic [DATA_W-1:0]     rxShift;
  logic [FRAME_BITS-1:0] txShift;
  logic                  cmdWrite;
  logic                  dataWrite;

  assign cmdWrite  = regWrEn && !regSel && !busy;
  assign dataWrite = regWrEn && regSel && !busy;
  assign startReq  = regWrEn && !regSel && regWrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWr   <= 1'b0;
      cmdDiv  <= '0;
      cmdReg  <= '0;
      cmdPhy  <= '0;
    end else if (cmdWrite) begin
      cmdWr   <= regWrData[1];
      cmdReg  <= regWrData[8:4];
      cmdPhy  <= regWrData[16:12];
      cmdDiv  <= regWrData[20 +: DIV_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (dataWrite) begin
      dataReg <= regWrData[DATA_W-1:0];
    end else if (strb.done && !cmdWr) begin
      dataReg <= rxShift;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strb.load)
        txShift <= {{PRE_W{1'b1}}, 2'b01,
                    regWrData[1] ? 2'b01 : 2'b10,
                    regWrData[16:12], regWrData[8:4], 2'b10, dataReg};
      else if (strb.shift)
        txShift <= txShift << 1;
      if (strb.sample)
        rxShift <= {rxShift[DATA_W-2:0], mdioIn};
    end
  end

  assign mdioOut    = txShift[FRAME_BITS-1];
  assign dataRdData = dataReg;
  assign cmdRdData  = {10'b0, 2'(cmdDiv), 3'b0, cmdPhy, 3'b0, cmdReg, 2'b0, cmdWr, busy};
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int BASE_HALF = 8,
  parameter int DIV_W     = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic [31:0] regWrData,
  output logic [31:0] cmdRdData,
  output logic [15:0] dataRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdio_strb_t       strb;
  logic             busy;
  logic             startReq;
  logic             cmdWr;
  logic [DIV_W-1:0] cmdDiv;

  mdio_ctrl #(.BASE_HALF(BASE_HALF), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmdWr(cmdWr),
    .cmdDiv(cmdDiv), .strb(strb), .busy(busy), .mdc(mdc), .mdioOe(mdioOe)
  );

  mdio_dp #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .strb(strb), .busy(busy), .mdioIn(mdioIn),
    .startReq(startReq), .cmdWr(cmdWr), .cmdDiv(cmdDiv),
    .cmdRdData(cmdRdData), .dataRdData(dataRdData), .mdioOut(mdioOut)
  );
endmodule

// File: rtl/mdio_chk.sv
module mdio_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic        regSel,
  input logic [31:0] regWrData,
  input logic [31:0] cmdRdData,
  input logic [15:0] dataRdData,
  input logic        mdc,
  input logic        mdioOe
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdRdData[0] && regWrEn && !regSel && regWrData[0]) |=> cmdRdData[0]); // R2
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !cmdRdData[0] |-> !mdc); // R8
  AST_IDLE_OE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cmdRdData[0] |-> !mdioOe); // R8
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRdData[0] && $past(cmdRdData[0])) |-> $stable(cmdRdData[21:1])); // R6
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRdData[0] && $past(cmdRdData[0])) |-> $stable(dataRdData)); // R7
endmodule

bind mdio_cmd_engine mdio_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
  .regWrData(regWrData), .cmdRdData(cmdRdData), .dataRdData(dataRdData),
  .mdc(mdc), .mdioOe(mdioOe)
);

// File: tb/sim_mdio_cmd_engine.sv
module sim_mdio_cmd_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] cmdRdData;
  logic [15:0] dataRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int testCnt = 0;
  int failCnt = 0;
  int capIdx = 64;
  logic [63:0] capOut, capOe;
  logic [15:0] rdVal = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mdio_cmd_engine u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .cmdRdData(cmdRdData), .dataRdData(dataRdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY model: capture on rising MDC, answer after falling MDC
  always @(posedge mdc) begin
    if (capIdx < 64) begin
      capOut[63 - capIdx] = mdioOut;
      capOe[63 - capIdx]  = mdioOe;
      capIdx = capIdx + 1;
    end
  end
  always @(negedge mdc) begin
    if (capIdx >= 48 && capIdx < 64) mdioIn = rdVal[63 - capIdx];
    else mdioIn = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expFrame(input logic wr, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFFFFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg, 2'b10, d};
  endfunction

  function automatic logic [31:0] expCmd(input logic wr, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic [1:0] div,
                                          input logic busy);
    return {10'b0, div, 3'b0, phy, 3'b0, rg, 2'b0, wr, busy};
  endfunction

  task automatic regWrite(input logic sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic runTxn(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] d, input logic [1:0] div);
    int n;
    int expLen;
    logic [31:0] cmd;
    logic [15:0] preData;
    preData = wr ? d : ~d;
    rdVal = d;
    regWrite(1'b1, {16'hA5A5, preData});
    capIdx = 0;
    cmd = expCmd(wr, phy, rg, div, 1'b1);
    @(negedge clk);
    regWrEn = 1'b1; regSel = 1'b0; regWrData = cmd;
    @(negedge clk);
    regWrEn = 1'b0;
    n = 0;
    while (cmdRdData[0] && n < 20000) begin
      n++;
      if (n == 100) begin // R6 poke: command while busy
        regWrEn = 1'b1; regSel = 1'b0; regWrData = ~cmd | 32'h1;
      end else if (n == 101) begin // R7 poke: data while busy
        regWrEn = 1'b1; regSel = 1'b1; regWrData = 32'h0000_5A3C ^ {16'h0, d};
      end else begin
        regWrEn = 1'b0;
      end
      @(negedge clk);
    end
    regWrEn = 1'b0;
    expLen = 128 * (8 << div);
    chk("R2/R5 busy length", 64'(n), 64'(expLen));
    chk("R6/R9 command fields after busy write", {32'h0, cmdRdData}, {32'h0, expCmd(wr, phy, rg, div, 1'b0)});
    chk("R8 mdc/oe idle low", {62'h0, mdc, mdioOe}, 64'h0);
    if (wr) begin
      chk("R3 write frame", capOut, expFrame(1'b1, phy, rg, d));
      chk("R3 write enable", capOe, {64{1'b1}});
      chk("R7 data register unchanged", {48'h0, dataRdData}, {48'h0, d});
    end else begin
      chk("R4 read frame head", {18'h0, capOut[63:18]}, {18'h0, expFrame(1'b0, phy, rg, 16'h0) >> 18});
      chk("R4 read enable release", capOe, {{46{1'b1}}, 18'h0});
      chk("R4 read data latched", {48'h0, dataRdData}, {48'h0, d});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    testCnt++; failCnt++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1D5EED);
    repeat (3) @(negedge clk);
    chk("R1 reset command", {32'h0, cmdRdData}, 64'h0);
    chk("R1 reset data", {48'h0, dataRdData}, 64'h0);
    chk("R1 reset pins", {62'h0, mdc, mdioOe}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    // R9: idle config write without start
    regWrite(1'b0, 32'h0031_A372);
    repeat (20) @(negedge clk);
    chk("R9 config no start", {32'h0, cmdRdData}, {32'h0, expCmd(1'b1, 5'h1A, 5'h17, 2'd3, 1'b0)});
    chk("R9 no mdc toggle", {63'h0, mdc}, 64'h0);
    // directed corners
    runTxn(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 2'd0);
    runTxn(1'b0, 5'h00, 5'h00, 16'h0000, 2'd0);
    runTxn(1'b0, 5'h15, 5'h0A, 16'h8001, 2'd3);
    runTxn(1'b1, 5'h01, 5'h10, 16'h1234, 2'd2);
    // random
    for (int i = 0; i < 8; i++) begin
      logic [31:0] r;
      r = $urandom;
      runTxn(r[0], r[5:1], r[10:6], r[26:11], {1'b0, r[27]});
    end
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule